// File: doc/BRIEF.md
# SPI EEPROM Page-Write Sequencer

This block is an SPI master that stores a run of 16-bit words into a byte-addressed serial EEPROM. A host pulses `start` with a starting word offset and a word count. The block then pulls the words one at a time from a valid/ready stream and produces every chip-select frame the device needs. Word offsets become byte addresses. Each word leaves low byte first. When a transfer reaches the end of a device page, the block closes the frame and opens a new one.

Each page burst has two frames. The first carries only the write-enable command. After a standby gap, the second carries the write opcode, the byte address and the data bytes of that page. For devices with an 8-bit address field, the ninth byte-address bit travels inside the write opcode. When the last frame closes, the block waits a fixed settle time and then reports completion. A request whose offset or count does not fit the device is refused with an error pulse, and no SPI activity follows.

Top module: `spi_eeprom_page_wr`

## Requirements
- R1: A start request is accepted only when the offset is below WORD_SIZE, the count is nonzero and the count does not exceed WORD_SIZE minus the offset. On any other request, `err` is high for exactly one cycle, in the cycle after `start`. In that case `busy` stays low and chip select never goes low. A request that ends exactly on the last word is accepted.
- R2: Every page burst starts with a frame holding only the write-enable byte 0x06. Chip select then stays high for 2×SCK_HALF cycles. A second frame follows, and its first byte is the write opcode.
- R3: The write opcode is 0x02. With ADDR_BITS = 8 and a burst starting word offset of 128 or more, the opcode is 0x0A instead (bit 3 carries byte-address bit 8).
- R4: After the opcode, the frame carries the byte address, which is twice the burst's first word offset. The address is sent as ADDR_BITS/8 bytes, most significant byte first. With ADDR_BITS = 8 this is the low 8 bits.
- R5: Each data word is sent low byte (bits 7:0) first, then high byte. Each byte goes most significant bit first, so every word takes 16 SCK pulses.
- R6: A burst may end before the last word. This happens when, after a word, twice the next word offset is a multiple of PAGE_BYTES. The frame then closes and a new write-enable plus write burst starts at that next offset. When the last word lands on a page end, no empty burst follows.
- R7: The SPI link runs in mode 0. SCK idles low and rises only while chip select is low. MOSI does not change while SCK is high. Each SCK phase lasts SCK_HALF clock cycles.
- R8: `word_ready` is high only inside a write frame, while the block waits for the next word. Exactly the requested number of words is taken. While no word is offered, SCK stays low and no bit is shifted.
- R9: After reset, `spi_cs_n` is 1 and `spi_sck`, `busy`, `word_ready`, `done` and `err` are 0. `busy` is high from the cycle after an accepted `start` until the transfer ends. `done` pulses for one cycle, SETTLE_CYCLES cycles after chip select rises for the last time, and `busy` is low in that same cycle.
- R10: A `start` pulse while `busy` is high is ignored. It causes no error, changes no frame content and causes no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| start_ofs | input | IDX_W | First word offset |
| word_cnt | input | IDX_W | Number of words to write |
| word_valid | input | 1 | Stream word available |
| word_data | input | 16 | Stream word |
| word_ready | output | 1 | Block takes the offered word this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse after settle |
| err | output | 1 | One-cycle pulse for a refused request |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |

## Verification
The bench runs transfers that cross a page edge mid-run and one that starts just below word 128, so the opcode bit flips between two bursts of one transfer. A sequencer that tested the page edge on the current word instead of the next one would split the frames one word late. A block that folded in the high bit from the transfer's first offset would send the wrong opcode on the second burst. Two full pages ending exactly on a page edge expose a trailing empty burst. A run that fills the last words of the device checks that the bounds test is not off by one. Each rejected request (offset past the end, count one too many, count of zero) must produce an error pulse and no frame. Stalled word streams check that SCK freezes rather than clocking out stale bits, a start pulse in mid-transfer must leave the frames untouched, and the settle wait is measured from the last chip-select rise.

// File: rtl/eep_wr_pkg.sv
package eep_wr_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_HIBIT = 8'h08;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WREN,
    ST_GAP_A,
    ST_OPC,
    ST_ADR,
    ST_REQ,
    ST_DLO,
    ST_DHI,
    ST_GAP_B,
    ST_SETTLE
  } seq_st_e;

endpackage

// File: rtl/eep_range_chk.sv
module eep_range_chk #(
  parameter int WORD_SIZE = 256,
  parameter int IDX_W     = 16
) (
  input  logic [IDX_W-1:0] ofs,
  input  logic [IDX_W-1:0] cnt,
  output logic             ok
);

  localparam logic [31:0] WS = 32'(WORD_SIZE);

  logic [31:0] o32;
  logic [31:0] c32;

  always_comb begin
    o32 = 32'(ofs);
    c32 = 32'(cnt);
    ok  = (o32 < WS) && (c32 != 32'd0) && (c32 <= (WS - o32));
  end

endmodule

// File: rtl/eep_byte_tx.sv
module eep_byte_tx #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  output logic       sck,
  output logic       mosi,
  output logic       active,
  output logic       fin
);

  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [7:0]    sh_q, sh_d;
  logic [2:0]    bit_q, bit_d;
  logic [DW-1:0] div_q, div_d;
  logic          sck_q, sck_d;
  logic          act_q, act_d;
  logic          fin_q, fin_d;
  logic          half_end;

  always_comb begin
    sh_d     = sh_q;
    bit_d    = bit_q;
    div_d    = div_q;
    sck_d    = sck_q;
    act_d    = act_q;
    fin_d    = 1'b0;
    half_end = (div_q == DW'(HALF - 1));
    if (act_q) begin
      if (half_end) begin
        div_d = '0;
        if (!sck_q) begin
          sck_d = 1'b1;
        end else begin
          sck_d = 1'b0;
          if (bit_q == 3'd7) begin
            act_d = 1'b0;
            fin_d = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
            sh_d  = {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        div_d = div_q + DW'(1);
      end
    end else if (load) begin
      sh_d  = din;
      bit_d = '0;
      div_d = '0;
      sck_d = 1'b0;
      act_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
      div_q <= '0;
      sck_q <= 1'b0;
      act_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      bit_q <= bit_d;
      div_q <= div_d;
      sck_q <= sck_d;
      act_q <= act_d;
      fin_q <= fin_d;
    end
  end

  assign sck    = sck_q;
  assign mosi   = sh_q[7];
  assign active = act_q;
  assign fin    = fin_q;

  // data must hold while the device samples on the high phase
  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(sh_q[7]));

  // the sequencer never hands over a byte while one is still shifting
  assert_load_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !act_q);

endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_wr_pkg::*;
#(
  parameter int WORD_SIZE     = 256,
  parameter int IDX_W         = 16,
  parameter int ADDR_BITS     = 8,
  parameter int PAGE_BYTES    = 16,
  parameter int SCK_HALF      = 2,
  parameter int SETTLE_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] ofs_in,
  input  logic [IDX_W-1:0] cnt_in,
  input  logic             range_ok,
  input  logic             word_valid,
  input  logic [15:0]      word_data,
  output logic             word_ready,
  output logic             tx_load,
  output logic [7:0]       tx_byte,
  input  logic             tx_fin,
  output logic             cs_n,
  output logic             busy,
  output logic             done,
  output logic             err
);

  localparam int ADDR_BYTES = ADDR_BITS / 8;
  localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int PAGE_WORDS = PAGE_BYTES / 2;
  localparam int PW_B       = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
  localparam int GAP        = 2 * SCK_HALF;
  localparam int GAP_W      = $clog2(GAP + 1);
  localparam int SC_W       = $clog2(SETTLE_CYCLES + 1);

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] ofs_q, ofs_d;
  logic [IDX_W-1:0] rem_q, rem_d;
  logic [7:0]       hi_q, hi_d;
  logic [AB_W-1:0]  ab_q, ab_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [SC_W-1:0]  set_q, set_d;
  logic             cs_n_q, cs_n_d;
  logic             done_q, done_d;
  logic             err_q, err_d;

  logic [IDX_W-1:0] ofs_nx;
  logic [31:0]      badr;
  logic             page_edge;
  logic             hi_sel;
  logic [7:0]       opc;

  function automatic logic [7:0] adr_byte(input logic [31:0] a, input int k);
    return 8'(a >> (8 * k));
  endfunction

  // the ninth byte-address bit only exists as an opcode bit on 8-bit parts
  if (ADDR_BITS == 8) begin : g_hibit
    assign hi_sel = (32'(ofs_q) >= 32'd128);
  end else begin : g_nohibit
    assign hi_sel = 1'b0;
  end

  assign ofs_nx    = ofs_q + IDX_W'(1);
  assign badr      = 32'(ofs_q) << 1;
  assign page_edge = (ofs_nx[PW_B-1:0] == '0);
  assign opc       = OP_WRITE | (hi_sel ? OP_HIBIT : 8'h00);

  always_comb begin
    st_d       = st_q;
    ofs_d      = ofs_q;
    rem_d      = rem_q;
    hi_d       = hi_q;
    ab_d       = ab_q;
    gap_d      = gap_q;
    set_d      = set_q;
    done_d     = 1'b0;
    err_d      = 1'b0;
    tx_load    = 1'b0;
    tx_byte    = 8'h00;
    word_ready = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (range_ok) begin
            ofs_d   = ofs_in;
            rem_d   = cnt_in;
            tx_load = 1'b1;
            tx_byte = OP_WREN;
            st_d    = ST_WREN;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_WREN: begin
        if (tx_fin) begin
          gap_d = '0;
          st_d  = ST_GAP_A;
        end
      end
      ST_GAP_A: begin
        if (gap_q == GAP_W'(GAP - 1)) begin
          tx_load = 1'b1;
          tx_byte = opc;
          st_d    = ST_OPC;
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
      ST_OPC: begin
        if (tx_fin) begin
          tx_load = 1'b1;
          tx_byte = adr_byte(badr, ADDR_BYTES - 1);
          ab_d    = AB_W'(ADDR_BYTES - 1);
          st_d    = ST_ADR;
        end
      end
      ST_ADR: begin
        if (tx_fin) begin
          if (ab_q == '0) begin
            st_d = ST_REQ;
          end else begin
            ab_d    = ab_q - AB_W'(1);
            tx_load = 1'b1;
            tx_byte = adr_byte(badr, int'(ab_q) - 1);
          end
        end
      end
      ST_REQ: begin
        word_ready = 1'b1;
        if (word_valid) begin
          hi_d    = word_data[15:8];
          tx_load = 1'b1;
          tx_byte = word_data[7:0];
          st_d    = ST_DLO;
        end
      end
      ST_DLO: begin
        if (tx_fin) begin
          tx_load = 1'b1;
          tx_byte = hi_q;
          st_d    = ST_DHI;
        end
      end
      ST_DHI: begin
        if (tx_fin) begin
          ofs_d = ofs_nx;
          rem_d = rem_q - IDX_W'(1);
          if (rem_q == IDX_W'(1)) begin
            set_d = '0;
            st_d  = ST_SETTLE;
          end else if (page_edge) begin
            gap_d = '0;
            st_d  = ST_GAP_B;
          end else begin
            st_d = ST_REQ;
          end
        end
      end
      ST_GAP_B: begin
        if (gap_q == GAP_W'(GAP - 1)) begin
          tx_load = 1'b1;
          tx_byte = OP_WREN;
          st_d    = ST_WREN;
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
      ST_SETTLE: begin
        if (set_q == SC_W'(SETTLE_CYCLES - 1)) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          set_d = set_q + SC_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
    cs_n_d = !((st_d == ST_WREN) || (st_d == ST_OPC) || (st_d == ST_ADR) ||
               (st_d == ST_REQ)  || (st_d == ST_DLO) || (st_d == ST_DHI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ofs_q  <= '0;
      rem_q  <= '0;
      hi_q   <= '0;
      ab_q   <= '0;
      gap_q  <= '0;
      set_q  <= '0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ofs_q  <= ofs_d;
      rem_q  <= rem_d;
      hi_q   <= hi_d;
      ab_q   <= ab_d;
      gap_q  <= gap_d;
      set_q  <= set_d;
      cs_n_q <= cs_n_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign cs_n = cs_n_q;
  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;

  // a refusal only follows a start that failed the range test while idle
  assert_err_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(start) && !$past(range_ok) && !busy));

  // words are requested only with the device selected
  assert_ready_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> !cs_n_q);

  // completion comes with the device released and the block idle
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cs_n_q && !busy && !err_q));

  // a start during a transfer leaves the remaining count alone
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && (st_q != ST_DHI)) |=> $stable(rem_q));

endmodule

// File: rtl/spi_eeprom_page_wr.sv
module spi_eeprom_page_wr #(
  parameter int WORD_SIZE     = 256,
  parameter int IDX_W         = 16,
  parameter int ADDR_BITS     = 8,
  parameter int PAGE_BYTES    = 16,
  parameter int SCK_HALF      = 2,
  parameter int SETTLE_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_ofs,
  input  logic [IDX_W-1:0] word_cnt,
  input  logic             word_valid,
  input  logic [15:0]      word_data,
  output logic             word_ready,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       range_ok;
  logic       tx_load;
  logic [7:0] tx_byte;
  logic       tx_fin;
  logic       tx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  eep_range_chk #(
    .WORD_SIZE (WORD_SIZE),
    .IDX_W     (IDX_W)
  ) i_range (
    .ofs (start_ofs),
    .cnt (word_cnt),
    .ok  (range_ok)
  );

  eep_seq #(
    .WORD_SIZE     (WORD_SIZE),
    .IDX_W         (IDX_W),
    .ADDR_BITS     (ADDR_BITS),
    .PAGE_BYTES    (PAGE_BYTES),
    .SCK_HALF      (SCK_HALF),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (start),
    .ofs_in     (start_ofs),
    .cnt_in     (word_cnt),
    .range_ok   (range_ok),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_ready (word_ready),
    .tx_load    (tx_load),
    .tx_byte    (tx_byte),
    .tx_fin     (tx_fin),
    .cs_n       (spi_cs_n),
    .busy       (busy),
    .done       (done),
    .err        (err)
  );

  eep_byte_tx #(
    .HALF (SCK_HALF)
  ) i_tx (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load   (tx_load),
    .din    (tx_byte),
    .sck    (spi_sck),
    .mosi   (spi_mosi),
    .active (tx_active),
    .fin    (tx_fin)
  );

  // serial clock pulses only inside a selected frame
  assert_sck_frame_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    spi_sck |-> !spi_cs_n);

  // while waiting on the stream the link is frozen
  assert_stall_sck_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    word_ready |-> (!spi_sck && !tx_active));

endmodule

// File: tb/test_spi_eeprom_page_wr.sv
module test_spi_eeprom_page_wr;

  localparam int WS     = 256;
  localparam int PB     = 16;
  localparam int HALF   = 2;
  localparam int SETTLE = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_ofs = '0;
  logic [15:0] word_cnt = '0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic        word_ready, busy, done, err, spi_cs_n, spi_sck, spi_mosi;

  always #5 clk = ~clk;

  spi_eeprom_page_wr #(
    .WORD_SIZE(WS), .IDX_W(16), .ADDR_BITS(8), .PAGE_BYTES(PB),
    .SCK_HALF(HALF), .SETTLE_CYCLES(SETTLE)
  ) i_spi_eeprom_page_wr (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ofs(start_ofs),
    .word_cnt(word_cnt), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .busy(busy), .done(done), .err(err),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // line monitor
  logic       p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
  logic [7:0] cur_b = '0;
  int         cur_bits = 0, cur_len = 0;
  logic [7:0] obs_b[$];
  int         obs_len[$];
  int         last_rise = 0, done_seen = 0, err_seen = 0, proto_bad = 0;
  int         cs_falls = 0, done_gap = 0;
  logic       done_busy = 1'b0;

  // reference model
  logic [7:0]  exp_b[$];
  int          exp_len[$];
  logic [15:0] words[$];

  // word source
  logic [15:0] wq[$];
  int          stall_len = 0, gap_c = 0, acc = 0;
  logic        pend = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (spi_sck && spi_cs_n) proto_bad++;
      if (word_ready && spi_sck) proto_bad++;
      if (p_sck && spi_sck && (spi_mosi !== p_mosi)) proto_bad++;
      if (!p_sck && spi_sck) begin
        cur_b = {cur_b[6:0], spi_mosi};
        cur_bits++;
        if (cur_bits == 8) begin
          obs_b.push_back(cur_b);
          cur_len++;
          cur_bits = 0;
        end
      end
      if (p_cs && !spi_cs_n) cs_falls++;
      if (!p_cs && spi_cs_n) begin
        if (cur_bits != 0) proto_bad++;
        obs_len.push_back(cur_len);
        cur_len = 0;
        cur_bits = 0;
        last_rise = cyc;
      end
      if (done) begin
        done_seen++;
        done_gap = cyc - last_rise;
        done_busy = busy;
      end
      if (err) err_seen++;
    end
    p_sck = spi_sck;
    p_cs = spi_cs_n;
    p_mosi = spi_mosi;
  end

  always @(negedge clk) begin
    if (pend) begin
      wq.delete(0);
      acc++;
      gap_c = 0;
    end
    if (wq.size() > 0 && gap_c >= stall_len) begin
      word_valid = 1'b1;
      word_data = wq[0];
    end else begin
      word_valid = 1'b0;
      gap_c++;
    end
    pend = word_valid && word_ready;
  end

  function automatic void build_exp(input int ofs, input int cnt);
    int w;
    w = 0;
    exp_b.delete();
    exp_len.delete();
    while (w < cnt) begin
      int n;
      exp_b.push_back(8'h06);
      exp_len.push_back(1);
      exp_b.push_back(((ofs + w) >= 128) ? 8'h0A : 8'h02);
      exp_b.push_back(8'(((ofs + w) * 2) & 255));
      n = 2;
      do begin
        exp_b.push_back(words[w][7:0]);
        exp_b.push_back(words[w][15:8]);
        n += 2;
        w++;
      end while (w < cnt && (((ofs + w) * 2) % PB) != 0);
      exp_len.push_back(n);
    end
  endfunction

  task automatic compare_frames();
    int pe, po;
    chk(obs_len.size() == exp_len.size(), "R6 frame count", obs_len.size(), exp_len.size());
    pe = 0;
    po = 0;
    for (int f = 0; f < exp_len.size() && f < obs_len.size(); f++) begin
      bit ok;
      int ea, eb, pos;
      string req;
      ok = (obs_len[f] == exp_len[f]);
      ea = obs_len[f];
      eb = exp_len[f];
      req = (exp_len[f] == 1) ? "R2 frame length" : "R6 frame length";
      if (ok) begin
        for (int k = 0; k < exp_len[f]; k++) begin
          if (ok && obs_b[po + k] !== exp_b[pe + k]) begin
            ok = 1'b0;
            ea = int'(obs_b[po + k]);
            eb = int'(exp_b[pe + k]);
            pos = k;
            if (exp_len[f] == 1) req = "R2 enable byte";
            else if (pos == 0) req = "R3 opcode";
            else if (pos == 1) req = "R4 address";
            else req = "R5 data byte";
          end
        end
      end
      chk(ok, req, ea, eb);
      pe += exp_len[f];
      po += obs_len[f];
    end
  endtask

  task automatic run_xfer(input int ofs, input int cnt, input int stall, input bit poke);
    int t;
    obs_b.delete();
    obs_len.delete();
    words.delete();
    for (int i = 0; i < cnt; i++) words.push_back(16'((i * 16'h1357) ^ (ofs << 4) ^ 16'hC3A5));
    build_exp(ofs, cnt);
    acc = 0;
    done_seen = 0;
    err_seen = 0;
    proto_bad = 0;
    stall_len = stall;
    for (int i = 0; i < cnt; i++) wq.push_back(words[i]);
    @(negedge clk);
    start_ofs = 16'(ofs);
    word_cnt = 16'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      start_ofs = 16'd0;
      word_cnt = 16'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done_seen == 0 && t < 20000) begin
      @(posedge clk);
      t++;
    end
    repeat (5) @(negedge clk);
    compare_frames();
    chk(acc == cnt, "R8 words taken", acc, cnt);
    chk(done_seen == 1, "R10 done pulses", done_seen, 1);
    chk(done_gap == SETTLE, "R9 settle gap", done_gap, SETTLE);
    chk(done_busy == 1'b0, "R9 busy at done", int'(done_busy), 0);
    chk(proto_bad == 0, "R7 line protocol", proto_bad, 0);
    chk(err_seen == 0, "R10 no error", err_seen, 0);
    wq.delete();
  endtask

  task automatic run_bad(input int ofs, input int cnt);
    int f0;
    f0 = cs_falls;
    err_seen = 0;
    @(negedge clk);
    start_ofs = 16'(ofs);
    word_cnt = 16'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err === 1'b1, "R1 error pulse", int'(err), 1);
    chk(busy === 1'b0, "R1 stays idle", int'(busy), 0);
    repeat (10) @(negedge clk);
    chk(cs_falls == f0, "R1 no frame", cs_falls - f0, 0);
    chk(err_seen == 1, "R1 single pulse", err_seen, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(spi_cs_n === 1'b1, "R9 reset cs_n", int'(spi_cs_n), 1);
    chk(spi_sck === 1'b0, "R9 reset sck", int'(spi_sck), 0);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R9 reset flags",
        int'({busy, done, err}), 0);
    chk(word_ready === 1'b0, "R9 reset ready", int'(word_ready), 0);
    // single word inside one page
    run_xfer(3, 1, 0, 1'b0);
    // crosses a page edge after word 7 (R6)
    run_xfer(5, 6, 0, 1'b0);
    // crosses word 128, second burst gets the high bit (R3), with stalls (R8)
    run_xfer(126, 5, 3, 1'b0);
    // fills the device end exactly (R1) and a start while busy (R10)
    run_xfer(250, 6, 1, 1'b1);
    // two full pages, no empty trailing burst (R6)
    run_xfer(0, 16, 0, 1'b0);
    // refused requests (R1)
    run_bad(256, 1);
    run_bad(250, 7);
    run_bad(10, 0);
    run_bad(0, 257);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule